// File: doc/BRIEF.md
# Synthesizer Control Latch and Power-Down Sequencer

This block is the digital control front end of an integer-N frequency synthesizer. A three-wire serial port (serial clock, serial data, load strobe) shifts 24-bit words into an input register. When the load strobe rises, the word is moved into one of three latches. The two lowest bits of the word pick the latch. The control latch is decoded into the mode fields that the rest of the chip consumes: charge-pump current and gain, output power, core power, output multiplexer selection and phase-detector polarity.

The block also sequences power-down. Power-down can be immediate, or it can be synchronous, in which case it waits for edges of the reference-divider output. While powered down it drives the enables for the rest of the chip: counter hold, charge-pump high impedance, lock-detect reset, RF output enable with mute-until-lock, and the reference buffer. The serial register keeps working during power-down.

If the N latch is rewritten during power-down, a sequence checker watches the latch writes that follow power-up. It raises a sticky error when the required order or the minimum spacing (counted in reference cycles) is broken.

Top module: `synth_ctrl`

## Requirements
- R1: Serial data shifts in MSB first, one bit per rising serial clock. On a rising load strobe the word is transferred according to bits [1:0]: 00 goes to the control latch, 01 to the R latch, 10 to the N latch, and 11 is ignored. The R and N latches present bits [23:2] of their word on `r_word` and `n_word`.
- R2: A control word with bit 20 = 1 and bit 21 = 0 sets `pd_active` on the clock edge that samples the load strobe high.
- R3: A control word with bits 20 and 21 both 1 sets `pd_active` on the second rising edge of `ref_div` sampled after the load. An edge of `ref_div` sampled in the same cycle as the load is not counted.
- R4: While `pd_active` is high, `r_hold`, `n_hold`, `tmo_hold`, `cp_hiz` and `ld_rst` are high, and `rf_en` and `refbuf_en` are low.
- R5: The serial register and the latches keep accepting words during power-down.
- R6: A control word with bit 20 = 0 clears `pd_active` on its load edge, which releases the holds and the lock-detect reset. It also cancels a pending synchronous entry.
- R7: With bit 11 set and the block not powered down, `rf_en` follows `lock_in`. With bit 11 clear, `rf_en` is high outside power-down.
- R8: `cp_gain` shows bit 10. `cp_cur` shows bits [16:14] when bit 10 is 0 and bits [19:17] when bit 10 is 1.
- R9: Bit 9 forces `cp_hiz` high. Bit 4 forces `r_hold` and `n_hold` high and leaves `tmo_hold` unaffected.
- R10: After an N-latch write made during power-down, power-up must be followed by an R write, then a control write, then an N write, with at least `min_gap` rising `ref_div` edges between the control and N writes. Any other N write in that sequence sets `seq_err`, which stays set until reset.
- R11: The control latch decodes `mux_sel` from bits [7:5], `pd_pol` from bit 8, `out_pwr` from bits [13:12] and `core_pwr` from bits [3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock (sampled) |
| sdata | input | 1 | Serial data |
| sload | input | 1 | Load strobe, rising edge transfers |
| ref_div | input | 1 | Reference-divider output |
| lock_in | input | 1 | Lock indication |
| min_gap | input | GAP_W | Required reference edges between control and N writes |
| pd_active | output | 1 | Powered down |
| r_hold | output | 1 | Hold R counter in load state |
| n_hold | output | 1 | Hold N (A/B) counters in load state |
| tmo_hold | output | 1 | Hold timeout counter |
| cp_hiz | output | 1 | Charge pump high impedance |
| ld_rst | output | 1 | Lock-detect reset |
| rf_en | output | 1 | RF output enable |
| refbuf_en | output | 1 | Reference buffer enable |
| cp_gain | output | 1 | Selected current set |
| cp_cur | output | 3 | Selected charge-pump current code |
| mux_sel | output | 3 | Output multiplexer select |
| pd_pol | output | 1 | Phase-detector polarity |
| out_pwr | output | 2 | Output power level |
| core_pwr | output | 2 | Core power level |
| r_word | output | 22 | R latch payload |
| n_word | output | 22 | N latch payload |
| seq_err | output | 1 | Sticky sequence error |

## Verification
The bench builds the block with `GAP_W` = 4 and drives `min_gap` to 3. This keeps the power-up interval to a few reference pulses, so one run can show an N write that meets the spacing and one that comes a single edge short of it. Short, hand-made reference pulses also let the bench count the exact edge on which synchronous entry takes effect, and show that a cancelled entry never happens.

// File: rtl/synth_ctrl.sv
module synth_ctrl #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             sload,
  input  logic             ref_div,
  input  logic             lock_in,
  input  logic [GAP_W-1:0] min_gap,
  output logic             pd_active,
  output logic             r_hold,
  output logic             n_hold,
  output logic             tmo_hold,
  output logic             cp_hiz,
  output logic             ld_rst,
  output logic             rf_en,
  output logic             refbuf_en,
  output logic             cp_gain,
  output logic [2:0]       cp_cur,
  output logic [2:0]       mux_sel,
  output logic             pd_pol,
  output logic [1:0]       out_pwr,
  output logic [1:0]       core_pwr,
  output logic [21:0]      r_word,
  output logic [21:0]      n_word,
  output logic             seq_err
);
  localparam int WORD_W = 24;

  typedef enum logic [1:0] {S_IDLE, S_WANT_R, S_WANT_C, S_GAP} seq_t;

  logic [WORD_W-1:0] sr, ctrl;
  logic sclk_q, sload_q, ref_q;
  logic sync_arm, sync_cnt, n_dirty;
  seq_t st;
  logic [GAP_W-1:0] gap_cnt;

  logic sck_rise, load_rise, ref_rise, ld_c, ld_r, ld_n, pd1, pd2;
  assign sck_rise  = sclk & ~sclk_q;
  assign load_rise = sload & ~sload_q;
  assign ref_rise  = ref_div & ~ref_q;
  assign ld_c = load_rise && sr[1:0] == 2'b00;
  assign ld_r = load_rise && sr[1:0] == 2'b01;
  assign ld_n = load_rise && sr[1:0] == 2'b10;
  assign pd1 = sr[20];
  assign pd2 = sr[21];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      ref_q   <= 1'b0;
      sr      <= '0;
    end else begin
      sclk_q  <= sclk;
      sload_q <= sload;
      ref_q   <= ref_div;
      if (sck_rise) sr <= {sr[WORD_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      r_word <= '0;
      n_word <= '0;
    end else begin
      if (ld_c) ctrl   <= sr;
      if (ld_r) r_word <= sr[WORD_W-1:2];
      if (ld_n) n_word <= sr[WORD_W-1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_active <= 1'b0;
      sync_arm  <= 1'b0;
      sync_cnt  <= 1'b0;
    end else if (ld_c) begin
      sync_cnt <= 1'b0;
      if (!pd1) begin
        pd_active <= 1'b0;
        sync_arm  <= 1'b0;
      end else if (!pd2) begin
        pd_active <= 1'b1;
        sync_arm  <= 1'b0;
      end else begin
        sync_arm <= ~pd_active;
      end
    end else if (sync_arm && ref_rise) begin
      if (sync_cnt) begin
        pd_active <= 1'b1;
        sync_arm  <= 1'b0;
      end else begin
        sync_cnt <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      n_dirty <= 1'b0;
      seq_err <= 1'b0;
      gap_cnt <= '0;
    end else begin
      if (ld_n && pd_active) n_dirty <= 1'b1;
      if (ld_c && !pd1 && pd_active) begin
        st      <= n_dirty ? S_WANT_R : S_IDLE;
        n_dirty <= 1'b0;
      end else begin
        case (st)
          S_WANT_R:
            if (ld_r) st <= S_WANT_C;
            else if (ld_n) begin
              seq_err <= 1'b1;
              st      <= S_IDLE;
            end
          S_WANT_C:
            if (ld_c && !pd1) begin
              st      <= S_GAP;
              gap_cnt <= '0;
            end else if (ld_n) begin
              seq_err <= 1'b1;
              st      <= S_IDLE;
            end
          S_GAP:
            if (ld_n) begin
              if (gap_cnt < min_gap) seq_err <= 1'b1;
              st <= S_IDLE;
            end else if (ref_rise && gap_cnt < min_gap) begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  assign r_hold    = pd_active | ctrl[4];
  assign n_hold    = pd_active | ctrl[4];
  assign tmo_hold  = pd_active;
  assign cp_hiz    = pd_active | ctrl[9];
  assign ld_rst    = pd_active;
  assign refbuf_en = ~pd_active;
  assign rf_en     = ~pd_active & (~ctrl[11] | lock_in);
  assign cp_gain   = ctrl[10];
  assign cp_cur    = ctrl[10] ? ctrl[19:17] : ctrl[16:14];
  assign mux_sel   = ctrl[7:5];
  assign pd_pol    = ctrl[8];
  assign out_pwr   = ctrl[13:12];
  assign core_pwr  = ctrl[3:2];
endmodule

// File: rtl/synth_ctrl_chk.sv
module synth_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sload,
  input logic        ref_div,
  input logic        lock_in,
  input logic [23:0] sr,
  input logic        pd_active,
  input logic        r_hold,
  input logic        n_hold,
  input logic        tmo_hold,
  input logic        cp_hiz,
  input logic        ld_rst,
  input logic        rf_en,
  input logic        refbuf_en,
  input logic [23:0] ctrl,
  input logic        seq_err
);
  // R2
  async_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload) && sr[1:0] == 2'b00 && sr[20] && !sr[21] |=> pd_active);

  // R6
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload) && sr[1:0] == 2'b00 && !sr[20] |=> !pd_active);

  // R3
  pd_entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> $past(sload) || $past(ref_div));

  // R4
  pd_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> r_hold && n_hold && tmo_hold && cp_hiz && ld_rst && !rf_en && !refbuf_en);

  // R7
  mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> !pd_active && (lock_in || !ctrl[11]));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
endmodule

bind synth_ctrl synth_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .sload(sload), .ref_div(ref_div), .lock_in(lock_in),
  .sr(sr), .pd_active(pd_active), .r_hold(r_hold), .n_hold(n_hold),
  .tmo_hold(tmo_hold), .cp_hiz(cp_hiz), .ld_rst(ld_rst), .rf_en(rf_en),
  .refbuf_en(refbuf_en), .ctrl(ctrl), .seq_err(seq_err)
);

// File: tb/tb_synth_ctrl.sv
module tb_synth_ctrl;
  localparam int GAP_W = 4;
  logic clk = 0, rst_n = 0, sclk = 0, sdata = 0, sload = 0, ref_div = 0, lock_in = 0;
  logic [GAP_W-1:0] min_gap = 4'd3;
  logic pd_active, r_hold, n_hold, tmo_hold, cp_hiz, ld_rst, rf_en, refbuf_en, cp_gain, pd_pol, seq_err;
  logic [2:0] cp_cur, mux_sel;
  logic [1:0] out_pwr, core_pwr;
  logic [21:0] r_word, n_word;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  synth_ctrl #(.GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
    .ref_div(ref_div), .lock_in(lock_in), .min_gap(min_gap),
    .pd_active(pd_active), .r_hold(r_hold), .n_hold(n_hold), .tmo_hold(tmo_hold),
    .cp_hiz(cp_hiz), .ld_rst(ld_rst), .rf_en(rf_en), .refbuf_en(refbuf_en),
    .cp_gain(cp_gain), .cp_cur(cp_cur), .mux_sel(mux_sel), .pd_pol(pd_pol),
    .out_pwr(out_pwr), .core_pwr(core_pwr), .r_word(r_word), .n_word(n_word),
    .seq_err(seq_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk); sdata = w[i]; sclk = 0;
      @(negedge clk); sclk = 1;
      @(negedge clk);
    end
    sclk = 0;
    @(negedge clk); sload = 1;
    @(negedge clk); sload = 0;
    @(negedge clk);
  endtask

  task automatic ref_pulse();
    @(negedge clk); ref_div = 1;
    repeat (2) @(negedge clk);
    ref_div = 0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [23:0] cw(bit pd1, bit pd2, bit mute, bit gain, bit hiz,
                                     bit crst, logic [2:0] c1, logic [2:0] c2);
    logic [23:0] w = '0;
    w[20] = pd1; w[21] = pd2; w[11] = mute; w[10] = gain; w[9] = hiz; w[4] = crst;
    w[16:14] = c1; w[19:17] = c2;
    return w;
  endfunction

  task automatic t_reset();
    check("R4 reset pd", pd_active, 0);
    check("R7 reset rf_en", rf_en, 1);
    check("R10 reset err", seq_err, 0);
  endtask

  task automatic t_latches();
    send({22'h2A5A5A, 2'b01});
    check("R1 r_word", r_word, 22'h2A5A5A);
    send({22'h135791, 2'b10});
    check("R1 n_word", n_word, 22'h135791);
    send({22'h3FFFFF, 2'b11});
    check("R1 ignored addr r", r_word, 22'h2A5A5A);
    check("R1 ignored addr n", n_word, 22'h135791);
    check("R1 ignored addr ctrl", {mux_sel, out_pwr}, 0);
  endtask

  task automatic t_decode();
    logic [23:0] w = cw(0, 0, 0, 0, 0, 0, 3'd5, 3'd2);
    w[7:5] = 3'd6; w[8] = 1; w[13:12] = 2'd3; w[3:2] = 2'd1;
    send(w);
    check("R11 mux_sel", mux_sel, 6);
    check("R11 pd_pol", pd_pol, 1);
    check("R11 out_pwr", out_pwr, 3);
    check("R11 core_pwr", core_pwr, 1);
    check("R8 gain0 cur", cp_cur, 5);
    send(cw(0, 0, 0, 1, 0, 0, 3'd5, 3'd2));
    check("R8 gain1 cur", cp_cur, 2);
    check("R8 gain bit", cp_gain, 1);
    send(cw(0, 0, 0, 0, 1, 1, 0, 0));
    check("R9 hiz", cp_hiz, 1);
    check("R9 crst holds", {r_hold, n_hold, tmo_hold}, 3'b110);
    send(cw(0, 0, 1, 0, 0, 0, 0, 0));
    lock_in = 0; @(negedge clk);
    check("R7 muted unlocked", rf_en, 0);
    lock_in = 1; @(negedge clk);
    check("R7 muted locked", rf_en, 1);
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    lock_in = 0; @(negedge clk);
    check("R7 unmuted", rf_en, 1);
  endtask

  task automatic t_async();
    send(cw(1, 0, 0, 0, 0, 0, 0, 0));
    check("R2 async pd", pd_active, 1);
    check("R4 effects", {r_hold, n_hold, tmo_hold, cp_hiz, ld_rst, rf_en, refbuf_en}, 7'b1111100);
    send({22'h0ABCDE, 2'b01});
    check("R5 R latch live in pd", r_word, 22'h0ABCDE);
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    check("R6 exit", {pd_active, r_hold, ld_rst, refbuf_en}, 4'b0001);
  endtask

  task automatic t_sync();
    send(cw(1, 1, 0, 0, 0, 0, 0, 0));
    check("R3 not yet", pd_active, 0);
    ref_pulse();
    check("R3 after one edge", pd_active, 0);
    ref_pulse();
    check("R3 after two edges", pd_active, 1);
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    check("R6 exit sync", pd_active, 0);
    send(cw(1, 1, 0, 0, 0, 0, 0, 0));
    ref_pulse();
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    ref_pulse();
    ref_pulse();
    check("R6 cancel pending", pd_active, 0);
  endtask

  task automatic t_seq();
    send(cw(1, 0, 0, 0, 0, 0, 0, 0));
    send({22'h001111, 2'b10});
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    send({22'h000222, 2'b01});
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    repeat (3) ref_pulse();
    send({22'h001111, 2'b10});
    check("R10 legal order", seq_err, 0);
    send(cw(1, 0, 0, 0, 0, 0, 0, 0));
    send({22'h003333, 2'b10});
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    send({22'h000222, 2'b01});
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    repeat (2) ref_pulse();
    send({22'h003333, 2'b10});
    check("R10 short gap", seq_err, 1);
    send({22'h000444, 2'b01});
    check("R10 sticky", seq_err, 1);
  endtask

  task automatic t_order();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    send(cw(1, 0, 0, 0, 0, 0, 0, 0));
    send({22'h005555, 2'b10});
    send(cw(0, 0, 0, 0, 0, 0, 0, 0));
    send({22'h005555, 2'b10});
    check("R10 N before R", seq_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latches();
    t_decode();
    t_async();
    t_sync();
    t_seq();
    t_order();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule